// File: doc/BRIEF.md
# SPI Register Port with Time Snapshot

This block is the serial front end of a timekeeping register file. A host selects it, sends one command byte and then any number of data bytes in the same select period. The top bit of the command byte picks the direction (set for a write) and the lower seven bits give the starting location. After each data byte the location pointer steps forward and wraps at the last location, so long bursts cycle through the register space.

The seven time locations are owned by the timekeeping core. Reads of them never see the live counters directly: a shadow copy is taken when the select goes active and again each time a burst steps from the last location back to location 0, so a burst read returns one consistent time. Writes to any location are handed to the core as a one-cycle strobe carrying location and data. The remaining control locations are held here and exposed as a flat bus. Bits that are defined as constant zero are masked on the way in and on the way out. A bus-block input, driven by supply supervision, shuts off every read and write while it is high.

The serial pins are sampled through synchronizers in the system clock domain. Data moves most significant bit first; the host samples on the trailing clock edge and the block drives on the leading edge, with the idle clock level set by a parameter.

Top module: `rtc_spi_port`

## Requirements
- R1: After reset the output enable is low, no write strobe is issued and every control location reads as 00h.
- R2: The first byte of a select period is a command: bit 7 = 1 means write, bit 7 = 0 means read, bits 6:0 give the start location; data bits move MSB first, sampled by the block on the trailing serial clock edge and driven by it on the leading edge.
- R3: After each data byte at a valid location the pointer increments, and from location 13h it wraps to 00h; this holds for read and write bursts alike (command 13h wraps to 00h, command 93h wraps to 80h).
- R4: Locations 14h through 7Fh are reserved: data bytes there produce no write strobe, leave the output enable low and do not move the pointer, so a burst starting at 7Fh never reaches 00h.
- R5: When the select goes active, the live time bytes (locations 00h–06h) are copied into the shadow that serves reads of those locations for the rest of the burst.
- R6: When a burst pointer steps from 13h to 00h, the shadow is refreshed from the live time bytes before the next data byte is read.
- R7: Each location has a mask of writable bits, and masked bits are stored and read as 0: 00h, 01h, 02h use 7Fh; 03h uses 07h; 04h uses 3Fh; 05h uses 9Fh; 12h uses C0h; 13h uses 01h; 06h through 11h use FFh.
- R8: A write data byte is committed on its eighth sampled bit as a one-cycle strobe with the location and masked data; control locations 07h–13h are also stored and appear on the control bus, location 07h in bits 7:0 and each next location one byte higher.
- R9: While the bus-block input is high no write strobe is issued, nothing is stored and the output enable stays low.
- R10: The output enable is low while the select is inactive and during the command byte; it is high only while data bytes of a read at a valid location are shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Drive enable for the serial output pad |
| bus_block | input | 1 | Blocks all reads and writes while high |
| time_live | input | TIME_REGS*8 | Live time bytes from the core, location 00h in bits 7:0 |
| wr_stb | output | 1 | One-cycle write commit to the core |
| wr_addr | output | 7 | Location of the committed byte |
| wr_data | output | 8 | Masked committed byte |
| ctl_regs | output | (LAST_LOC+1-TIME_REGS)*8 | Stored control locations, 07h in bits 7:0 |

## Verification
The checker watches on every cycle that a strobe never names a reserved location, never follows a blocked cycle and never lasts two cycles, that the output enable falls once the select is inactive, and that no masked bit of a stored control location is ever set. Burst wrapping at 13h, pointer freezing at reserved locations, and above all the consistency of the time snapshot (old time across the first pass, fresh time after the wrap) only show up in the bench's burst scenarios, where written values are swept across all control locations with several patterns and read back through the serial path.

// File: rtl/rtc_spi_pkg.sv
package rtc_spi_pkg;

   localparam int unsigned BYTE_W = 8;

   typedef logic [BYTE_W-1:0] byte_t;

   typedef enum logic {
      PH_CMD  = 1'b0,
      PH_DATA = 1'b1
   } phase_e;

   // Writable-bit mask of a location; anything past the last location is all-zero.
   function automatic byte_t loc_mask(input int unsigned loc, input int unsigned last);
      byte_t m;
      if (loc > last) begin
         m = '0;
      end else begin
         case (loc)
            0, 1, 2: m = 8'h7F;
            3:       m = 8'h07;
            4:       m = 8'h3F;
            5:       m = 8'h9F;
            18:      m = 8'hC0;
            19:      m = 8'h01;
            default: m = 8'hFF;
         endcase
      end
      return m;
   endfunction

endpackage

// File: rtl/rtc_spi_sync.sv
module rtc_spi_sync #(
   parameter int unsigned STAGES = 2,
   parameter bit          CPOL   = 1'b0
)(
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic cs_n,
   input  logic mosi,
   output logic sel,
   output logic sel_rise,
   output logic lead,
   output logic trail,
   output logic mosi_s
);

   if (STAGES < 2) begin : g_bad_stages
      $error("rtc_spi_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sclk_q, cs_q, mosi_q;
   logic              sclk_d, sel_d;
   logic              sclk_s, rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= {STAGES{CPOL}};
         cs_q   <= '1;
         mosi_q <= '0;
         sclk_d <= CPOL;
         sel_d  <= 1'b0;
      end else begin
         sclk_q <= {sclk_q[STAGES-2:0], sclk};
         cs_q   <= {cs_q[STAGES-2:0], cs_n};
         mosi_q <= {mosi_q[STAGES-2:0], mosi};
         sclk_d <= sclk_s;
         sel_d  <= sel;
      end
   end

   assign sclk_s   = sclk_q[STAGES-1];
   assign sel      = ~cs_q[STAGES-1];
   assign mosi_s   = mosi_q[STAGES-1];
   assign sel_rise = sel & ~sel_d;
   assign rise     = sclk_s & ~sclk_d;
   assign fall     = ~sclk_s & sclk_d;

   if (CPOL == 1'b0) begin : g_idle_low
      assign lead  = rise;
      assign trail = fall;
   end else begin : g_idle_high
      assign lead  = fall;
      assign trail = rise;
   end

endmodule

// File: rtl/rtc_spi_shift.sv
module rtc_spi_shift import rtc_spi_pkg::*; #(
   localparam int unsigned CNT_W = $clog2(BYTE_W)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             trail,
   input  logic             mosi,
   output logic [CNT_W-1:0] bit_idx,
   output logic             byte_done,
   output byte_t            rx_byte
);

   logic [BYTE_W-2:0] rx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_idx <= '0;
         rx_sh   <= '0;
      end else if (!sel) begin
         bit_idx <= '0;
      end else if (trail) begin
         bit_idx <= bit_idx + 1'b1;
         rx_sh   <= {rx_sh[BYTE_W-3:0], mosi};
      end
   end

   assign byte_done = sel & trail & (bit_idx == CNT_W'(BYTE_W-1));
   assign rx_byte   = {rx_sh, mosi};

endmodule

// File: rtl/rtc_spi_snap.sv
module rtc_spi_snap #(
   parameter int unsigned WIDTH = 56
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [WIDTH-1:0] live,
   output logic [WIDTH-1:0] shadow
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    shadow <= '0;
      else if (take) shadow <= live;
   end

endmodule

// File: rtl/rtc_spi_regs.sv
module rtc_spi_regs import rtc_spi_pkg::*; #(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned BASE   = 7,
   parameter int unsigned COUNT  = 13,
   localparam int unsigned Q_W   = COUNT * BYTE_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  byte_t             wdata,
   output logic [Q_W-1:0]    q
);

   for (genvar k = 0; k < COUNT; k++) begin : g_loc
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[k*BYTE_W +: BYTE_W] <= '0;
         else if (we && waddr == ADDR_W'(BASE + k))
            q[k*BYTE_W +: BYTE_W] <= wdata;
      end
   end

endmodule

// File: rtl/rtc_spi_port.sv
module rtc_spi_port import rtc_spi_pkg::*; #(
   parameter int unsigned TIME_REGS   = 7,
   parameter int unsigned LAST_LOC    = 19,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          CPOL        = 1'b0,
   localparam int unsigned ADDR_W   = BYTE_W - 1,
   localparam int unsigned CTL_REGS = LAST_LOC + 1 - TIME_REGS,
   localparam int unsigned TIME_W   = TIME_REGS * BYTE_W,
   localparam int unsigned CTL_W    = CTL_REGS * BYTE_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              spi_miso_oe,
   input  logic              bus_block,
   input  logic [TIME_W-1:0] time_live,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic [CTL_W-1:0]  ctl_regs
);

   if (TIME_REGS == 0 || TIME_REGS > LAST_LOC) begin : g_bad_time
      $error("rtc_spi_port: TIME_REGS must lie in 1..LAST_LOC");
   end
   if (LAST_LOC >= (1 << ADDR_W) - 1) begin : g_bad_last
      $error("rtc_spi_port: LAST_LOC must leave room for reserved locations");
   end

   localparam int unsigned    CNT_W  = $clog2(BYTE_W);
   localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_LOC);

   logic             sel, sel_rise, lead, trail, mosi_s;
   logic [CNT_W-1:0] bit_idx;
   logic             byte_done;
   byte_t            rx_byte;

   phase_e            phase;
   logic              wr_mode;
   logic [ADDR_W-1:0] ptr;
   logic              loc_ok, at_last, in_data;
   logic              commit, wrap_snap, snap_take;
   byte_t             wmask, wbyte, rd_val;
   logic [TIME_W-1:0] shadow;

   rtc_spi_sync #(
      .STAGES (SYNC_STAGES),
      .CPOL   (CPOL)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk     (spi_sclk),
      .cs_n     (spi_cs_n),
      .mosi     (spi_mosi),
      .sel      (sel),
      .sel_rise (sel_rise),
      .lead     (lead),
      .trail    (trail),
      .mosi_s   (mosi_s)
   );

   rtc_spi_shift u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel),
      .trail     (trail),
      .mosi      (mosi_s),
      .bit_idx   (bit_idx),
      .byte_done (byte_done),
      .rx_byte   (rx_byte)
   );

   // Pointer state and decode
   assign loc_ok    = (ptr <= LAST_A);
   assign at_last   = (ptr == LAST_A);
   assign in_data   = sel & (phase == PH_DATA) & loc_ok;
   assign commit    = byte_done & in_data & wr_mode & ~bus_block;
   assign wrap_snap = byte_done & in_data & at_last;
   assign snap_take = sel_rise | wrap_snap;
   assign wmask     = loc_mask(32'(ptr), LAST_LOC);
   assign wbyte     = rx_byte & wmask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_CMD;
         wr_mode <= 1'b0;
         ptr     <= '0;
      end else if (!sel) begin
         phase   <= PH_CMD;
         wr_mode <= 1'b0;
      end else if (byte_done) begin
         if (phase == PH_CMD) begin
            phase   <= PH_DATA;
            wr_mode <= rx_byte[BYTE_W-1];
            ptr     <= rx_byte[ADDR_W-1:0];
         end else if (loc_ok) begin
            ptr <= at_last ? '0 : ptr + 1'b1;
         end
      end
   end

   // Time shadow
   rtc_spi_snap #(
      .WIDTH (TIME_W)
   ) u_snap (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (snap_take),
      .live   (time_live),
      .shadow (shadow)
   );

   // Control location storage
   rtc_spi_regs #(
      .ADDR_W (ADDR_W),
      .BASE   (TIME_REGS),
      .COUNT  (CTL_REGS)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (commit),
      .waddr (ptr),
      .wdata (wbyte),
      .q     (ctl_regs)
   );

   // Write strobe to the core
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_stb  <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_stb <= commit;
         if (commit) begin
            wr_addr <= ptr;
            wr_data <= wbyte;
         end
      end
   end

   // Read value of the current location
   always_comb begin
      rd_val = '0;
      for (int i = 0; i < TIME_REGS; i++) begin
         if (ptr == ADDR_W'(i))
            rd_val = shadow[i*BYTE_W +: BYTE_W] & loc_mask(i, LAST_LOC);
      end
      for (int j = 0; j < CTL_REGS; j++) begin
         if (ptr == ADDR_W'(TIME_REGS + j))
            rd_val = ctl_regs[j*BYTE_W +: BYTE_W];
      end
   end

   // Serial output, driven on the leading edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spi_miso    <= 1'b0;
         spi_miso_oe <= 1'b0;
      end else if (!sel) begin
         spi_miso    <= 1'b0;
         spi_miso_oe <= 1'b0;
      end else if (lead) begin
         if (in_data && !wr_mode && !bus_block) begin
            spi_miso    <= rd_val[BYTE_W-1-32'(bit_idx)];
            spi_miso_oe <= 1'b1;
         end else begin
            spi_miso    <= 1'b0;
            spi_miso_oe <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/rtc_spi_port_chk.sv
module rtc_spi_port_chk import rtc_spi_pkg::*; #(
   parameter int unsigned ADDR_W    = 7,
   parameter int unsigned TIME_REGS = 7,
   parameter int unsigned LAST_LOC  = 19,
   parameter int unsigned CTL_W     = 104
)(
   input logic              clk,
   input logic              rst_n,
   input logic              sel,
   input logic              bus_block,
   input logic              spi_miso_oe,
   input logic              wr_stb,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [CTL_W-1:0]  ctl_regs
);

   localparam int unsigned CTL_REGS = CTL_W / BYTE_W;

   // R10
   oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> !spi_miso_oe);

   // R4
   rsv_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> (wr_addr <= ADDR_W'(LAST_LOC)));

   // R9
   blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_block |=> !wr_stb);

   // R8
   stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);

   for (genvar k = 0; k < CTL_REGS; k++) begin : g_bits
      // R7
      rsv_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ctl_regs[k*BYTE_W +: BYTE_W] & ~loc_mask(TIME_REGS + k, LAST_LOC)) == '0);
   end

endmodule

bind rtc_spi_port rtc_spi_port_chk #(
   .ADDR_W    (ADDR_W),
   .TIME_REGS (TIME_REGS),
   .LAST_LOC  (LAST_LOC),
   .CTL_W     (CTL_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sel         (sel),
   .bus_block   (bus_block),
   .spi_miso_oe (spi_miso_oe),
   .wr_stb      (wr_stb),
   .wr_addr     (wr_addr),
   .ctl_regs    (ctl_regs)
);

// File: tb/tb_rtc_spi_port.sv
module tb_rtc_spi_port;

   localparam int HB = 6;

   logic         clk = 1'b0;
   logic         rst_n, sclk, cs_n, mosi, bus_block;
   logic         miso, miso_oe, wr_stb;
   logic [55:0]  time_live;
   logic [6:0]   wr_addr;
   logic [7:0]   wr_data;
   logic [103:0] ctl_regs;

   always #2 clk = ~clk;

   rtc_spi_port dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .spi_sclk    (sclk),
      .spi_cs_n    (cs_n),
      .spi_mosi    (mosi),
      .spi_miso    (miso),
      .spi_miso_oe (miso_oe),
      .bus_block   (bus_block),
      .time_live   (time_live),
      .wr_stb      (wr_stb),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .ctl_regs    (ctl_regs)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   int         nlog = 0;
   logic [6:0] la [0:63];
   logic [7:0] ld [0:63];
   logic [7:0] exp_ctl [0:19];

   always @(negedge clk) begin
      if (rst_n && wr_stb && nlog < 64) begin
         la[nlog] = wr_addr;
         ld[nlog] = wr_data;
         nlog++;
      end
   end

   function automatic logic [7:0] bmask(input int loc);
      case (loc)
         0, 1, 2: return 8'h7F;
         3:       return 8'h07;
         4:       return 8'h3F;
         5:       return 8'h9F;
         18:      return 8'hC0;
         19:      return 8'h01;
         default: return (loc > 19) ? 8'h00 : 8'hFF;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, expv);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic sel_on();
      cs_n = 1'b0;
      tick(HB);
   endtask

   task automatic sel_off();
      tick(2);
      cs_n = 1'b1;
      tick(2*HB);
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oe_seen);
      oe_seen = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         mosi = tx[i];
         sclk = 1'b1;
         tick(HB);
         rx[i]   = miso;
         oe_seen = oe_seen | miso_oe;
         sclk = 1'b0;
         tick(HB);
      end
   endtask

   function automatic logic [7:0] ctl_at(input int loc);
      return ctl_regs[(loc-7)*8 +: 8];
   endfunction

   logic [7:0] ta [0:6];
   logic [7:0] tb [0:6];
   logic [7:0] tc [0:6];

   task automatic set_live(input int which);
      for (int k = 0; k < 7; k++)
         time_live[k*8 +: 8] = (which == 0) ? ta[k] : (which == 1) ? tb[k] : tc[k];
   endtask

   initial begin
      logic [7:0] rx;
      logic       oe;
      int         base;

      rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0; bus_block = 1'b0;
      time_live = '0;
      for (int k = 0; k < 20; k++) exp_ctl[k] = 8'h00;
      ta[0] = 8'hD9; ta[1] = 8'h7A; ta[2] = 8'hF3; ta[3] = 8'hFF; ta[4] = 8'h3F; ta[5] = 8'h9F; ta[6] = 8'h99;
      tb[0] = 8'h45; tb[1] = 8'hB2; tb[2] = 8'h12; tb[3] = 8'h06; tb[4] = 8'hE1; tb[5] = 8'h72; tb[6] = 8'h24;
      tc[0] = 8'h9C; tc[1] = 8'h33; tc[2] = 8'h08; tc[3] = 8'h0A; tc[4] = 8'h15; tc[5] = 8'h81; tc[6] = 8'h50;
      tick(5);
      rst_n = 1'b1;
      tick(5);

      // R1 reset state
      chk("R1 oe after reset", miso_oe, 0);
      chk("R1 no strobe after reset", nlog, 0);
      chk("R1 control locations zero", (ctl_regs == '0), 1);

      // R2 R8 R7 sweep of write bursts over all control locations
      for (int p = 0; p < 4; p++) begin
         base = nlog;
         sel_on();
         xfer(8'h87, rx, oe);
         chk("R10 oe low in command byte", oe, 0);
         for (int loc = 7; loc < 20; loc++) begin
            logic [7:0] d;
            d = 8'((loc*53 + p*97 + 17) ^ ((p % 2 == 1) ? 255 : 0));
            xfer(d, rx, oe);
            exp_ctl[loc] = d & bmask(loc);
         end
         sel_off();
         chk("R8 strobe count in write burst", nlog - base, 13);
         for (int k = 0; k < 13; k++) begin
            chk("R8 strobe location", la[base+k], 7 + k);
            chk("R7 strobe data masked", ld[base+k], exp_ctl[7+k]);
         end
         for (int loc = 7; loc < 20; loc++)
            chk("R8 control bus byte", ctl_at(loc), exp_ctl[loc]);
         base = nlog;
         sel_on();
         xfer(8'h07, rx, oe);
         for (int loc = 7; loc < 20; loc++) begin
            xfer(8'h00, rx, oe);
            chk("R2 read back MSB first", rx, exp_ctl[loc]);
            chk("R10 oe high in read data", oe, 1);
         end
         sel_off();
         chk("R2 read issues no strobe", nlog - base, 0);
         chk("R10 oe low after deselect", miso_oe, 0);
      end

      // R3 write burst wraps 93h to 80h
      base = nlog;
      sel_on();
      xfer(8'h92, rx, oe);
      xfer(8'hAA, rx, oe);
      xfer(8'h55, rx, oe);
      xfer(8'h3C, rx, oe);
      sel_off();
      exp_ctl[18] = 8'h80;
      exp_ctl[19] = 8'h01;
      chk("R3 wrap strobe count", nlog - base, 3);
      chk("R3 first location", la[base], 7'h12);
      chk("R7 data at 12h", ld[base], 8'h80);
      chk("R3 second location", la[base+1], 7'h13);
      chk("R7 data at 13h", ld[base+1], 8'h01);
      chk("R3 wrapped location", la[base+2], 7'h00);
      chk("R7 data at 00h", ld[base+2], 8'h3C);

      // R5 R6 R3 snapshot at select and at read wrap
      set_live(0);
      sel_on();
      set_live(1);
      xfer(8'h00, rx, oe);
      for (int n = 0; n < 22; n++) begin
         logic [7:0] e;
         xfer(8'h00, rx, oe);
         if (n < 7)       e = ta[n] & bmask(n);
         else if (n < 20) e = exp_ctl[n];
         else             e = tb[n-20] & bmask(n-20);
         if (n < 7)       chk("R5 time from select snapshot", rx, e);
         else if (n < 20) chk("R3 control in read burst", rx, e);
         else             chk("R6 time after wrap snapshot", rx, e);
      end
      sel_off();

      set_live(2);
      sel_on();
      xfer(8'h02, rx, oe);
      xfer(8'h00, rx, oe);
      chk("R5 fresh snapshot on new select", rx, tc[2] & bmask(2));
      xfer(8'h00, rx, oe);
      chk("R7 read mask at 03h", rx, tc[3] & bmask(3));
      sel_off();

      // R4 reserved locations
      base = nlog;
      sel_on();
      xfer(8'h95, rx, oe);
      xfer(8'hFF, rx, oe);
      xfer(8'hFF, rx, oe);
      sel_off();
      chk("R4 no strobe at 15h", nlog - base, 0);
      base = nlog;
      sel_on();
      xfer(8'hFF, rx, oe);
      xfer(8'h11, rx, oe);
      xfer(8'h22, rx, oe);
      xfer(8'h33, rx, oe);
      sel_off();
      chk("R4 pointer frozen at 7Fh", nlog - base, 0);
      for (int loc = 7; loc < 20; loc++)
         chk("R4 control unchanged", ctl_at(loc), exp_ctl[loc]);
      sel_on();
      xfer(8'h14, rx, oe);
      xfer(8'h00, rx, oe);
      chk("R4 no data at 14h", rx, 8'h00);
      chk("R4 oe low at 14h", oe, 0);
      sel_off();
      sel_on();
      xfer(8'h7F, rx, oe);
      xfer(8'h00, rx, oe);
      xfer(8'h00, rx, oe);
      chk("R4 oe low at 7Fh", oe, 0);
      sel_off();

      // R9 bus block
      bus_block = 1'b1;
      base = nlog;
      sel_on();
      xfer(8'h87, rx, oe);
      xfer(8'h5A, rx, oe);
      xfer(8'hA5, rx, oe);
      sel_off();
      chk("R9 no strobe when blocked", nlog - base, 0);
      chk("R9 location 07h kept", ctl_at(7), exp_ctl[7]);
      chk("R9 location 08h kept", ctl_at(8), exp_ctl[8]);
      sel_on();
      xfer(8'h07, rx, oe);
      xfer(8'h00, rx, oe);
      chk("R9 oe low when blocked", oe, 0);
      sel_off();
      bus_block = 1'b0;
      sel_on();
      xfer(8'h07, rx, oe);
      xfer(8'h00, rx, oe);
      chk("R9 read resumes after release", rx, exp_ctl[7]);
      chk("R10 oe high after release", oe, 1);
      sel_off();
      chk("R10 oe low when idle", miso_oe, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule